// File: doc/BRIEF.md
# Compare, Test and Skip Condition Unit

This unit decides whether a compare, skip, jump or bit-test instruction takes effect. It receives an operand word, a second word and a few control fields. The second word is either a comparison value or a bit mask. The control fields are an operation kind, a 3-bit condition code, a scope selection and a signed/unsigned select. One clock after a valid request, the unit presents a single condition flag.

The same flag picks one of the two words. Under the less-or-equal code this yields the minimum of the pair, and under greater-or-equal it yields the maximum. The sequencer needs no separate min/max datapath.

A compare can cover the whole word, the upper half, the lower half, or both halves at once. In both-halves scope the condition must hold in each half on its own terms. Bit tests use the same scope rule on the masked bits. Incrementing, decrementing, register writeback and program-counter sequencing all happen outside this unit.

Top module: `csk_cond_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid`=0, `out_cond`=0 and `out_pick`=0.
- R2: A request with `in_valid`=1 gives `out_valid`=1 on the following cycle. A cycle with `in_valid`=0 gives `out_valid`=0 on the following cycle, and `out_cond` and `out_pick` keep their previous values.
- R3: With `in_kind`=0 (compare), `in_code` selects the relation of operand to comparison word as follows: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 always, 5 greater-or-equal, 6 not-equal, 7 greater.
- R4: With `in_unsigned`=0 the compare treats values as two's complement. With `in_unsigned`=1 it treats them as unsigned magnitudes.
- R5: `in_scope` chooses the bits that are evaluated: 0 the whole word, 1 both halves, 2 the upper half only, 3 the lower half only. Both-halves scope is true only if the condition is true in each half independently. A half is treated as a value of its own width, with its top bit as the sign bit in signed mode.
- R6: `out_pick` equals the operand word when `out_cond`=1 and the comparison word otherwise. As a result, code 3 returns the minimum and code 5 returns the maximum.
- R7: With `in_kind`=1 (test), code 0 is true when any masked operand bit is set, and code 1 is true when no masked operand bit is set.
- R8: Test code 2 is true only when the mask is nonzero and every masked bit is set. Test code 3 is true only when the mask is nonzero and every masked bit is clear. A zero mask makes both of these false.
- R9: Test code 4 is true when any masked bit is clear. Test code 5 is true when no masked bit is clear. Test codes 6 and 7 are always false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 1 | 0 compare, 1 bit test |
| in_scope | input | 2 | 0 whole, 1 both halves, 2 upper, 3 lower |
| in_unsigned | input | 1 | 1 selects unsigned compare |
| in_code | input | 3 | Condition code |
| in_opnd | input | WORD_W | Operand word |
| in_cmp | input | WORD_W | Comparison word or mask |
| out_valid | output | 1 | Result present |
| out_cond | output | 1 | Condition true |
| out_pick | output | WORD_W | Operand if condition true, else comparison word |

## Verification
The bench builds the unit with the default `WORD_W` of 64, which makes the halves 32 bits wide. With that width, hex vectors can place the sign bits at positions 31 and 63 directly. This lets the vectors show the same word pair giving opposite results under whole-word and half-word scope, and under signed and unsigned mode. Zero masks, masks that are zero in only one half, and the reserved test codes are also driven at this width.

// File: rtl/csk_pkg.sv
package csk_pkg;

    typedef enum logic [2:0] {
        CC_NEVER  = 3'd0,
        CC_LT     = 3'd1,
        CC_EQ     = 3'd2,
        CC_LE     = 3'd3,
        CC_ALWAYS = 3'd4,
        CC_GE     = 3'd5,
        CC_NE     = 3'd6,
        CC_GT     = 3'd7
    } cmp_code_e;

    typedef enum logic [2:0] {
        TC_ANY_SET  = 3'd0,
        TC_NONE_SET = 3'd1,
        TC_ALL_SET  = 3'd2,
        TC_ALL_CLR  = 3'd3,
        TC_ANY_CLR  = 3'd4,
        TC_NONE_CLR = 3'd5,
        TC_RSVD6    = 3'd6,
        TC_RSVD7    = 3'd7
    } test_code_e;

    typedef enum logic [1:0] {
        SC_WHOLE = 2'd0,
        SC_BOTH  = 2'd1,
        SC_UPPER = 2'd2,
        SC_LOWER = 2'd3
    } scope_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic any_set;
        logic any_clr;
        logic mask_nz;
    } lane_flags_t;

    function automatic logic cmp_decide(cmp_code_e c, lane_flags_t f);
        case (c)
            CC_NEVER:  return 1'b0;
            CC_LT:     return f.lt;
            CC_EQ:     return f.eq;
            CC_LE:     return f.lt | f.eq;
            CC_ALWAYS: return 1'b1;
            CC_GE:     return ~f.lt;
            CC_NE:     return ~f.eq;
            default:   return ~f.lt & ~f.eq;
        endcase
    endfunction

    function automatic logic test_decide(test_code_e c, lane_flags_t f);
        case (c)
            TC_ANY_SET:  return f.any_set;
            TC_NONE_SET: return ~f.any_set;
            TC_ALL_SET:  return f.mask_nz & ~f.any_clr;
            TC_ALL_CLR:  return f.mask_nz & ~f.any_set;
            TC_ANY_CLR:  return f.any_clr;
            TC_NONE_CLR: return ~f.any_clr;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/csk_lane.sv
module csk_lane
    import csk_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              uns,
    output lane_flags_t       flags
);
    logic [LANE_W-1:0] hit_set;
    logic [LANE_W-1:0] hit_clr;

    always_comb begin
        hit_set        = a & b;
        hit_clr        = ~a & b;
        flags.lt       = uns ? (a < b) : ($signed(a) < $signed(b));
        flags.eq       = (a == b);
        flags.any_set  = |hit_set;
        flags.any_clr  = |hit_clr;
        flags.mask_nz  = |b;
    end
endmodule

// File: rtl/csk_judge.sv
module csk_judge
    import csk_pkg::*;
(
    input  lane_flags_t flags,
    input  logic        is_test,
    input  logic [2:0]  code,
    output logic        verdict
);
    always_comb begin
        if (is_test)
            verdict = test_decide(test_code_e'(code), flags);
        else
            verdict = cmp_decide(cmp_code_e'(code), flags);
    end
endmodule

// File: rtl/csk_cond_unit.sv
module csk_cond_unit
    import csk_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_kind,
    input  logic [1:0]        in_scope,
    input  logic              in_unsigned,
    input  logic [2:0]        in_code,
    input  logic [WORD_W-1:0] in_opnd,
    input  logic [WORD_W-1:0] in_cmp,
    output logic              out_valid,
    output logic              out_cond,
    output logic [WORD_W-1:0] out_pick
);
    localparam int HALF_W = WORD_W / 2;

    lane_flags_t whole_flags;
    logic        whole_v;
    logic [1:0]  half_v;
    logic        cond_c;

    csk_lane #(.LANE_W(WORD_W)) u_whole_lane (
        .a(in_opnd), .b(in_cmp), .uns(in_unsigned), .flags(whole_flags)
    );
    csk_judge u_whole_judge (
        .flags(whole_flags), .is_test(in_kind), .code(in_code), .verdict(whole_v)
    );

    // lane 0 is the lower half, lane 1 the upper half
    for (genvar g = 0; g < 2; g++) begin : g_half
        lane_flags_t hf;
        csk_lane #(.LANE_W(HALF_W)) u_lane (
            .a(in_opnd[g*HALF_W +: HALF_W]),
            .b(in_cmp[g*HALF_W +: HALF_W]),
            .uns(in_unsigned),
            .flags(hf)
        );
        csk_judge u_judge (
            .flags(hf), .is_test(in_kind), .code(in_code), .verdict(half_v[g])
        );
    end

    always_comb begin
        case (scope_e'(in_scope))
            SC_WHOLE: cond_c = whole_v;
            SC_BOTH:  cond_c = &half_v;
            SC_UPPER: cond_c = half_v[1];
            default:  cond_c = half_v[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cond  <= 1'b0;
            out_pick  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_cond <= cond_c;
                out_pick <= cond_c ? in_opnd : in_cmp;
            end
        end
    end
endmodule

// File: rtl/csk_cond_unit_chk.sv
module csk_cond_unit_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_kind,
    input logic [2:0]        in_code,
    input logic [WORD_W-1:0] in_opnd,
    input logic [WORD_W-1:0] in_cmp,
    input logic              out_valid,
    input logic              out_cond,
    input logic [WORD_W-1:0] out_pick
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_cond) && $stable(out_pick))); // R2
    AST_NEVER_FALSE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind && in_code == 3'd0) |=> !out_cond); // R3
    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind && in_code == 3'd4) |=> out_cond); // R3
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind && (in_code == 3'd2 || in_code == 3'd3) && in_cmp == '0)
        |=> !out_cond); // R8
    AST_RSVD_TEST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind && in_code[2:1] == 2'b11) |=> !out_cond); // R9
    AST_PICK_MATCH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_pick == (out_cond ? $past(in_opnd) : $past(in_cmp)))); // R6
endmodule

bind csk_cond_unit csk_cond_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_code(in_code), .in_opnd(in_opnd), .in_cmp(in_cmp),
    .out_valid(out_valid), .out_cond(out_cond), .out_pick(out_pick)
);

// File: tb/test_csk_cond_unit.sv
module test_csk_cond_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    typedef struct packed {
        logic        kind;
        logic [1:0]  scope;
        logic        uns;
        logic [2:0]  code;
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        // R3 R4 whole-word compares
        '{1'b0, 2'd0, 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},
        '{1'b0, 2'd0, 1'b1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
        '{1'b0, 2'd0, 1'b0, 3'd2, 64'h5, 64'h5, 1'b1},
        '{1'b0, 2'd0, 1'b0, 3'd7, 64'h5, 64'h3, 1'b1},
        '{1'b0, 2'd0, 1'b0, 3'd0, 64'h5, 64'h5, 1'b0},
        '{1'b0, 2'd0, 1'b0, 3'd4, 64'h5, 64'h3, 1'b1},
        '{1'b0, 2'd0, 1'b0, 3'd6, 64'h5, 64'h3, 1'b1},
        // R5 scopes
        '{1'b0, 2'd3, 1'b0, 3'd2, 64'h1234_5678_0000_0007, 64'hABCD_EF00_0000_0007, 1'b1},
        '{1'b0, 2'd2, 1'b0, 3'd2, 64'h1234_5678_0000_0007, 64'hABCD_EF00_0000_0007, 1'b0},
        '{1'b0, 2'd1, 1'b0, 3'd5, 64'h0000_0005_0000_0001, 64'h0000_0003_0000_0002, 1'b0},
        '{1'b0, 2'd1, 1'b0, 3'd5, 64'h0000_0005_0000_0003, 64'h0000_0003_0000_0002, 1'b1},
        '{1'b0, 2'd2, 1'b0, 3'd1, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000, 1'b1},
        '{1'b0, 2'd2, 1'b1, 3'd1, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000, 1'b0},
        '{1'b0, 2'd3, 1'b0, 3'd1, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b1},
        '{1'b0, 2'd0, 1'b0, 3'd1, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0},
        // R7 R8 R9 bit tests
        '{1'b1, 2'd0, 1'b0, 3'd0, 64'h0F, 64'h10, 1'b0},
        '{1'b1, 2'd0, 1'b0, 3'd1, 64'h0F, 64'h10, 1'b1},
        '{1'b1, 2'd0, 1'b0, 3'd2, 64'hFF, 64'h0F, 1'b1},
        '{1'b1, 2'd0, 1'b0, 3'd2, 64'hFF, 64'h0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 3'd3, 64'hF0, 64'h0F, 1'b1},
        '{1'b1, 2'd0, 1'b0, 3'd3, 64'hF0, 64'h0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 3'd4, 64'hFF, 64'h1F0, 1'b1},
        '{1'b1, 2'd0, 1'b0, 3'd5, 64'hFF, 64'h1F0, 1'b0},
        '{1'b1, 2'd1, 1'b0, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
        '{1'b1, 2'd2, 1'b0, 3'd0, 64'h1, 64'h1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 3'd7, 64'hFF, 64'hFF, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_kind = 1'b0;
    logic [1:0]   in_scope = '0;
    logic         in_unsigned = 1'b0;
    logic [2:0]   in_code = '0;
    logic [W-1:0] in_opnd = '0;
    logic [W-1:0] in_cmp = '0;
    logic         out_valid;
    logic         out_cond;
    logic [W-1:0] out_pick;

    int n_checks = 0;
    int n_errors = 0;

    csk_cond_unit #(.WORD_W(W)) i_csk_cond_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_scope(in_scope), .in_unsigned(in_unsigned), .in_code(in_code),
        .in_opnd(in_opnd), .in_cmp(in_cmp),
        .out_valid(out_valid), .out_cond(out_cond), .out_pick(out_pick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid    = 1'b1;
        in_kind     = v.kind;
        in_scope    = v.scope;
        in_unsigned = v.uns;
        in_code     = v.code;
        in_opnd     = v.a;
        in_cmp      = v.b;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {63'b0, out_valid}, 64'd0);
        check("R1 out_cond", {63'b0, out_cond}, 64'd0);
        check("R1 out_pick", out_pick, 64'd0);
        rst = 1'b0;

        // table walk: R3 R4 R5 R7 R8 R9, plus R6 pick and R2 valid
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R2 valid vec%0d", i), {63'b0, out_valid}, 64'd1);
            check($sformatf("R3-9 cond vec%0d", i), {63'b0, out_cond}, {63'b0, VEC[i].exp});
            check($sformatf("R6 pick vec%0d", i), out_pick, VEC[i].exp ? VEC[i].a : VEC[i].b);
        end

        // R6 minimum via code 3, maximum via code 5
        drive('{1'b0, 2'd0, 1'b0, 3'd3, 64'd3, 64'd7, 1'b1});
        @(negedge clk);
        check("R6 min", out_pick, 64'd3);
        drive('{1'b0, 2'd0, 1'b0, 3'd5, 64'd3, 64'd7, 1'b0});
        @(negedge clk);
        check("R6 max", out_pick, 64'd7);

        // R2 idle cycle holds outputs, changed inputs ignored
        in_valid = 1'b0;
        in_code  = 3'd4;
        in_opnd  = 64'hDEAD;
        @(negedge clk);
        check("R2 idle valid", {63'b0, out_valid}, 64'd0);
        check("R2 idle cond", {63'b0, out_cond}, 64'd0);
        check("R2 idle pick", out_pick, 64'd7);

        // R1 reset mid-run
        drive('{1'b0, 2'd0, 1'b0, 3'd4, 64'h55, 64'h66, 1'b1});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 rerst valid", {63'b0, out_valid}, 64'd0);
        check("R1 rerst cond", {63'b0, out_cond}, 64'd0);
        check("R1 rerst pick", out_pick, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule